// File: doc/BRIEF.md
# UART Receive Queue with Interrupt Identification

This block sits between the receive shift register of a 16550-style UART and the CPU register file. Each character that the shifter assembles is pushed in with its parity, framing and break tags. The character goes into a 16-entry first-in first-out queue. The error tags go into sticky line status flags. The CPU pops characters through the receive buffer read strobe and reads the line status through its own strobe. Reading the line status clears the error flags.

The block compares the queue occupancy with a trigger level that a 2-bit field selects. It raises a data-available interrupt while the occupancy is at or above that level. A pending line status interrupt outranks the data-available interrupt. The resulting condition appears as a 4-bit identification code and as a single interrupt line. Both interrupt sources work only while the queue enable bit is high. Each source also has its own enable bit.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: Characters are popped in the order they were pushed. A pulse on `rbr_rd` with a non-empty queue removes the oldest character, and that character appears on `rbr_q` after the next clock edge.
- R2: `trig_sel` sets the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. While `fifo_en` and `ie_rda` are high, `irq` goes high in the cycle after a push that brings the occupancy up to the trigger level.
- R3: The data-available interrupt drops in the cycle after a pop that brings the occupancy below the trigger level.
- R4: `iir_q` reads 0x4 exactly when the data-available condition of R2 and R3 holds and no line status interrupt is pending.
- R5: While a line status interrupt is pending, `iir_q` reads 0x6, whatever the occupancy.
- R6: `lsr_q` bit 0 (data ready) is high in the cycle after a character is accepted. It is low whenever the queue is empty.
- R7: When no interrupt is pending, `irq` is low and `iir_q` reads 0x1. This is also the state after reset, where `lsr_q` and `rbr_q` are zero.
- R8: The `lsr_q` error bits are sticky: bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break. Bits 7:5 read zero. Any error bit that is set raises a line status interrupt when `ie_rls` is high. The error bits hold their value during the `lsr_rd` cycle and are zero after it.
- R9: A push that arrives while 16 characters are held sets the overrun bit and is discarded. The stored characters remain unchanged.
- R10: A pulse on `rbr_rd` with an empty queue leaves `rbr_q` at its previous value and the occupancy at zero.
- R11: With `fifo_en` low, neither interrupt source raises `irq` or changes `iir_q` from 0x1. With `ie_rda` low, data-available is suppressed. With `ie_rls` low, line status is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Shifter delivers one character this cycle |
| push_data | input | 8 | Character from the shifter |
| push_pe | input | 1 | Parity error tag of the character |
| push_fe | input | 1 | Framing error tag of the character |
| push_bi | input | 1 | Break tag of the character |
| fifo_en | input | 1 | Queue enable bit of the control register |
| trig_sel | input | 2 | Trigger level select |
| ie_rda | input | 1 | Data-available interrupt enable |
| ie_rls | input | 1 | Line status interrupt enable |
| rbr_rd | input | 1 | Receive buffer read strobe (pops one character) |
| lsr_rd | input | 1 | Line status read strobe (clears error bits) |
| rbr_q | output | 8 | Last character popped |
| lsr_q | output | 8 | Line status: data ready and error bits |
| iir_q | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count appears at the ports one cycle after the push or pop that corrupts it. It shows as `irq` or `iir_q` switching at the wrong character, or as data ready disagreeing with the number of characters held. The bench sweeps every trigger level over a full fill and a full drain to catch this. A wrong pointer shows as a character out of order on `rbr_q` at the pop that reaches it. A lost or stuck sticky flag shows in `lsr_q` and in the 0x6 code in the cycle after the push or line status read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } line_err_t;

    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_RDA  = 4'h4,
        IID_RLS  = 4'h6
    } iid_t;

    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          accept,
    output logic          overrun,
    output logic          do_pop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full;

    assign full    = (count == CW'(DEPTH));
    assign accept  = push && !full;
    assign overrun = push && full;
    assign do_pop  = pop_req && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= nxt(wr_ptr);
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(accept) - CW'(do_pop);
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_discard_r9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop_req) |=> count == CW'(DEPTH));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (pop_req && count == '0 && !push) |=> count == '0);

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr import uart_rxq_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  line_err_t set_err,
    input  logic      clr,
    output line_err_t flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= set_err | (clr ? line_err_t'('0) : flags);
    end

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr && !clr) |=> flags.ovr);

    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_err.ovr) |=> !flags.ovr);

    p_par_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_err.par) |=> !flags.par);

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq import uart_rxq_pkg::*; #(
    parameter int CW = 5
) (
    input  logic          fifo_en,
    input  logic          ie_rda,
    input  logic          ie_rls,
    input  line_err_t     errs,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    output iid_t          iid,
    output logic          irq
);
    logic rls_pend, rda_pend;

    always_comb begin
        rls_pend = fifo_en && ie_rls && (|errs);
        rda_pend = fifo_en && ie_rda && (count >= trig);
        if (rls_pend)      iid = IID_RLS;
        else if (rda_pend) iid = IID_RDA;
        else               iid = IID_NONE;
        irq = rls_pend || rda_pend;
    end

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq import uart_rxq_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_pe,
    input  logic              push_fe,
    input  logic              push_bi,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              ie_rda,
    input  logic              ie_rls,
    input  logic              rbr_rd,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rbr_q,
    output logic [7:0]        lsr_q,
    output logic [3:0]        iir_q,
    output logic              irq
);
    logic [DATA_W-1:0] head;
    logic [CW-1:0]     count, trig;
    logic              accept, overrun, do_pop;
    line_err_t         set_err, flags;
    iid_t              iid;

    rxq_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push_valid),
        .wr_data (push_data),
        .pop_req (rbr_rd),
        .head    (head),
        .count   (count),
        .accept  (accept),
        .overrun (overrun),
        .do_pop  (do_pop)
    );

    always_comb begin
        set_err.ovr = overrun;
        set_err.par = accept && push_pe;
        set_err.frm = accept && push_fe;
        set_err.brk = accept && push_bi;
    end

    rxq_lsr u_lsr (
        .clk     (clk),
        .rst     (rst),
        .set_err (set_err),
        .clr     (lsr_rd),
        .flags   (flags)
    );

    assign trig = CW'(trig_level(trig_sel, DEPTH));

    rxq_irq #(.CW(CW)) u_irq (
        .fifo_en (fifo_en),
        .ie_rda  (ie_rda),
        .ie_rls  (ie_rls),
        .errs    (flags),
        .count   (count),
        .trig    (trig),
        .iid     (iid),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)         rbr_q <= '0;
        else if (do_pop) rbr_q <= head;
    end

    assign lsr_q = {3'b000, flags.brk, flags.frm, flags.par, flags.ovr, count != '0};
    assign iir_q = iid;

    p_dr_set_r6: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !rbr_rd) |=> lsr_q[0]);

    p_idle_code_r7: assert property (@(posedge clk) disable iff (rst)
        !irq |-> iir_q == 4'h1);

    p_ls_priority_r5: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ie_rls && (|lsr_q[4:1])) |-> iir_q == 4'h6);

    p_rda_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (iir_q == 4'h4) |-> (fifo_en && ie_rda && lsr_q[0]));

    p_empty_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rbr_rd && !lsr_q[0]) |=> $stable(rbr_q));

endmodule

// File: tb/uart_rx_fifo_irq_test.sv
module uart_rx_fifo_irq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       push_valid, push_pe, push_fe, push_bi;
    logic [7:0] push_data;
    logic       fifo_en, ie_rda, ie_rls, rbr_rd, lsr_rd;
    logic [1:0] trig_sel;
    logic [7:0] rbr_q, lsr_q;
    logic [3:0] iir_q;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart_rx_fifo_irq uut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .push_pe(push_pe), .push_fe(push_fe), .push_bi(push_bi),
        .fifo_en(fifo_en), .trig_sel(trig_sel), .ie_rda(ie_rda), .ie_rls(ie_rls),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rbr_q(rbr_q), .lsr_q(lsr_q),
        .iir_q(iir_q), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_char(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
        push_valid = 1'b1; push_data = d; push_pe = pe; push_fe = fe; push_bi = bi;
        @(negedge clk);
        push_valid = 1'b0; push_pe = 1'b0; push_fe = 1'b0; push_bi = 1'b0;
    endtask

    task automatic pop_char();
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
    endtask

    task automatic read_lsr(input logic [7:0] exp_during, input string req);
        lsr_rd = 1'b1;
        #1 chk(req, 16'(lsr_q), 16'(exp_during));
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    function automatic int trig_of(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; push_valid = 1'b0; push_data = '0; push_pe = 1'b0; push_fe = 1'b0;
        push_bi = 1'b0; fifo_en = 1'b1; trig_sel = 2'd0; ie_rda = 1'b1; ie_rls = 1'b0;
        rbr_rd = 1'b0; lsr_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset lsr", 16'(lsr_q), 16'h0);
        chk("R7 reset iir", 16'(iir_q), 16'h1);
        chk("R7 reset irq", 16'(irq), 16'h0);
        chk("R7 reset rbr", 16'(rbr_q), 16'h0);

        // R2 R3 R4 R6 R1: full fill and drain at every trigger level
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            #1;
            for (int k = 1; k <= 16; k++) begin
                push_char(8'(s * 16 + k), 1'b0, 1'b0, 1'b0);
                chk("R2 irq on fill", 16'(irq), 16'(k >= trig_of(s)));
                chk("R4 iir on fill", 16'(iir_q), (k >= trig_of(s)) ? 16'h4 : 16'h1);
                chk("R6 dr on fill", 16'(lsr_q[0]), 16'h1);
            end
            for (int j = 1; j <= 16; j++) begin
                pop_char();
                chk("R1 order", 16'(rbr_q), 16'(s * 16 + j));
                chk("R3 irq on drain", 16'(irq), 16'((16 - j) >= trig_of(s)));
                chk("R4 iir on drain", 16'(iir_q), ((16 - j) >= trig_of(s)) ? 16'h4 : 16'h1);
                chk("R6 dr on drain", 16'(lsr_q[0]), 16'((16 - j) != 0));
            end
        end

        // R9 R5 R8: overrun on a full queue
        trig_sel = 2'd3; ie_rls = 1'b1;
        for (int k = 0; k < 16; k++) push_char(8'hA0 + 8'(k), 1'b0, 1'b0, 1'b0);
        chk("R9 no overrun yet", 16'(lsr_q), 16'h01);
        push_char(8'h55, 1'b0, 1'b0, 1'b0);
        chk("R9 overrun bit", 16'(lsr_q), 16'h03);
        chk("R5 rls over rda", 16'(iir_q), 16'h6);
        chk("R8 rls irq", 16'(irq), 16'h1);
        read_lsr(8'h03, "R8 lsr read value");
        chk("R8 overrun cleared", 16'(lsr_q), 16'h01);
        chk("R5 back to rda", 16'(iir_q), 16'h4);
        for (int k = 0; k < 16; k++) begin
            pop_char();
            chk("R9 contents intact", 16'(rbr_q), 16'h00A0 + 16'(k));
        end

        // R10: read of an empty queue
        pop_char();
        chk("R10 rbr held", 16'(rbr_q), 16'h00AF);
        chk("R10 still empty", 16'(lsr_q[0]), 16'h0);
        chk("R10 no irq", 16'(irq), 16'h0);
        push_char(8'h3C, 1'b0, 1'b0, 1'b0);
        pop_char();
        chk("R10 count stayed zero", 16'(lsr_q[0]), 16'h0);
        chk("R10 next char", 16'(rbr_q), 16'h003C);

        // R8 R5 R11: each error tag
        trig_sel = 2'd0;
        for (int b = 0; b < 3; b++) begin
            push_char(8'h10 + 8'(b), b == 0, b == 1, b == 2);
            chk("R8 error bit", 16'(lsr_q), 16'h01 | (16'h04 << b));
            chk("R5 code 6", 16'(iir_q), 16'h6);
            ie_rls = 1'b0; #1;
            chk("R11 rls masked", 16'(iir_q), 16'h4);
            ie_rda = 1'b0; #1;
            chk("R11 both masked iir", 16'(iir_q), 16'h1);
            chk("R11 both masked irq", 16'(irq), 16'h0);
            ie_rls = 1'b1; ie_rda = 1'b1;
            read_lsr(8'h01 | (8'h04 << b), "R8 read with error");
            chk("R8 error cleared", 16'(lsr_q), 16'h01);
            pop_char();
            chk("R1 errored char data", 16'(rbr_q), 16'h0010 + 16'(b));
        end

        // R11: queue disabled
        fifo_en = 1'b0; trig_sel = 2'd1;
        push_char(8'h77, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) push_char(8'h78 + 8'(k), 1'b0, 1'b0, 1'b0);
        chk("R11 disabled irq", 16'(irq), 16'h0);
        chk("R11 disabled iir", 16'(iir_q), 16'h1);
        chk("R8 flag kept while disabled", 16'(lsr_q), 16'h05);
        fifo_en = 1'b1; #1;
        chk("R11 enabled rls", 16'(iir_q), 16'h6);
        read_lsr(8'h05, "R8 read after enable");
        chk("R2 rda at level 4", 16'(iir_q), 16'h4);
        for (int k = 0; k < 5; k++) pop_char();
        chk("R1 last of five", 16'(rbr_q), 16'h007B);
        chk("R7 idle", 16'(iir_q), 16'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule